// File: doc/BRIEF.md
# SMBus Byte Register Slave with Alert Response

This block is the serial front end of a small register-based peripheral on an SMBus or I2C bus. It watches the SCL and SDA lines through a synchroniser clocked by the system clock. It recognises start, repeated start and stop conditions, shifts bytes in and out most significant bit first, and pulls SDA low through an output-enable to acknowledge. Behind it sits a register block. The slave gives that block a register index, write data, a one-cycle write strobe and a one-cycle read strobe, and it takes back read data combinationally for the indexed register.

Two transactions are supported. A byte write is address with write, then index, then data. A byte read is address with write, then index, then a repeated start, then address with read, after which the slave sends one byte. The slave also answers the shared alert response address while the register block reports a pending alert. It replies with its own address and then tells the register block to release the alert. A clock-low timeout and a bus-idle detector, both counted in system-clock cycles, return the protocol engine to rest.

Top module: `smb_byte_slave`

## Requirements
- R1: The 7-bit device address is binary 0100 followed by the three strap bits (strap_i[2] most significant). An address byte whose upper seven bits equal it, with bit 0 = 0 (write), is acknowledged by driving sda_oe_o high during the ninth clock. Every other write address byte, the alert response address included, gets no acknowledge.
- R2: strap_i is sampled only while rst_n is low. Later changes to it do not change which address is acknowledged.
- R3: In a byte write, an index byte of value MAX_IDX (default 6) or less is acknowledged. The data byte that follows is acknowledged, and one wr_stb_o pulse is issued with reg_idx_o equal to the index and wr_data_o equal to the data. An index above MAX_IDX is not acknowledged, and no write strobe follows it.
- R4: In a byte read, the slave acknowledges its address with bit 0 = 1 and then sends rd_data_i for the stored index, MSB first. Exactly one rd_stb_o pulse is issued, when the byte is loaded, with reg_idx_o holding that index.
- R5: The alert response address 0001100 with bit 0 = 1 is acknowledged only while alert_pend_i is high. The slave then sends its own address followed by a 0 bit, and pulses alert_clr_o for one cycle once that byte has been sent.
- R6: While transmitting, if SDA reads low in a bit where the slave released it, the slave releases SDA for the rest of the byte. In an alert response this also means no alert_clr_o pulse.
- R7: When SCL stays low for TIMEOUT_CYC system cycles, the slave releases SDA and returns to rest. The next transaction is then served normally.
- R8: bus_idle_o goes low after a start. It goes high after a stop, or once SCL and SDA have both been high for IDLE_CYC cycles.
- R9: After reset, sda_oe_o is low, bus_idle_o is high and no strobe is pulsed.
- R10: A data byte after the first data byte of a byte write is not acknowledged and causes no write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; straps are latched while it is low |
| strap_i | input | 3 | Low three bits of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| alert_pend_i | input | 1 | Register block has an alert pending |
| alert_clr_o | output | 1 | One-cycle pulse after a completed alert response |
| reg_idx_o | output | IDX_W | Register index from the last accepted command byte |
| wr_data_o | output | 8 | Write data, valid with wr_stb_o |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| rd_stb_o | output | 1 | One-cycle pulse when the read byte is loaded |
| rd_data_i | input | 8 | Read data for reg_idx_o |
| bus_idle_o | output | 1 | Bus is free |

## Verification
The hardest case to reach is losing arbitration during an alert response. It needs a second device on the wire that drives a different address byte in the same bit slots. The bench models that contender as an extra open-drain pull on the shared SDA net. It picks a contender byte that wins at bit 3 and releases SDA at bit 2, where this slave would otherwise pull low. The master then reads the contender's byte intact, and no alert release pulse appears, only if the slave really left the bus. The clock-low timeout is reached by stopping the master in the middle of the acknowledge bit, while the slave is still pulling SDA low.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDAT,
      ST_TX,
      ST_SKIP
   } smb_state_e;

   localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic [STAGES-1:0] scl_q;
   logic [STAGES-1:0] sda_q;
   logic              scl_p;
   logic              sda_p;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  scl_q[0] <= 1'b1;
                  sda_q[0] <= 1'b1;
               end else begin
                  scl_q[0] <= scl_i;
                  sda_q[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  scl_q[g] <= 1'b1;
                  sda_q[g] <= 1'b1;
               end else begin
                  scl_q[g] <= scl_q[g-1];
                  sda_q[g] <= sda_q[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_o;
         sda_p <= sda_o;
      end
   end

   assign scl_o      = scl_q[STAGES-1];
   assign sda_o      = sda_q[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_p;
   assign scl_fall_o = ~scl_o & scl_p;
   assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
   assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;

endmodule

// File: rtl/smb_bus_watch.sv
module smb_bus_watch #(
   parameter int TIMEOUT_CYC = 2_500_000,
   parameter int IDLE_CYC    = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   input  logic start_i,
   input  logic stop_i,
   output logic timeout_o,
   output logic idle_hit_o,
   output logic bus_idle_o
);

   localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
   localparam int ID_W = $clog2(IDLE_CYC + 1);

   logic [TO_W-1:0] low_cnt;
   logic [ID_W-1:0] high_cnt;
   logic            both_high;

   assign both_high = scl_s_i & sda_s_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (scl_s_i) begin
         low_cnt <= '0;
      end else if (low_cnt != TO_W'(TIMEOUT_CYC)) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         high_cnt <= '0;
      end else if (!both_high) begin
         high_cnt <= '0;
      end else if (high_cnt != ID_W'(IDLE_CYC)) begin
         high_cnt <= high_cnt + 1'b1;
      end
   end

   assign timeout_o  = !scl_s_i && (low_cnt == TO_W'(TIMEOUT_CYC - 1));
   assign idle_hit_o = both_high && (high_cnt == ID_W'(IDLE_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_idle_o <= 1'b1;
      end else if (start_i) begin
         bus_idle_o <= 1'b0;
      end else if (stop_i || idle_hit_o) begin
         bus_idle_o <= 1'b1;
      end
   end

   assert_idle_after_stop_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> bus_idle_o);

   assert_busy_after_start_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !bus_idle_o);

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
   import smb_slave_pkg::*;
#(
   parameter int IDX_W   = 3,
   parameter int MAX_IDX = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [6:0]       dev_addr_i,
   input  logic             sda_s_i,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             timeout_i,
   input  logic             idle_hit_i,
   input  logic             alert_pend_i,
   input  logic [7:0]       rd_data_i,
   output logic             sda_oe_o,
   output logic             alert_clr_o,
   output logic [IDX_W-1:0] reg_idx_o,
   output logic [7:0]       wr_data_o,
   output logic             wr_stb_o,
   output logic             rd_stb_o
);

   smb_state_e state;
   smb_state_e nxt_state;
   smb_state_e dec_nxt;
   logic       ack_ph;
   logic [3:0] bit_cnt;
   logic [7:0] rx_sh;
   logic [7:0] tx_sh;
   logic       ara_mode;
   logic       dec_ack;
   logic       dec_ara;
   logic [7:0] tx_load;

   always_comb begin
      dec_ack = 1'b0;
      dec_ara = 1'b0;
      dec_nxt = ST_SKIP;
      case (state)
         ST_ADDR: begin
            if (rx_sh == {dev_addr_i, 1'b0}) begin
               dec_ack = 1'b1;
               dec_nxt = ST_CMD;
            end else if (rx_sh == {dev_addr_i, 1'b1}) begin
               dec_ack = 1'b1;
               dec_nxt = ST_TX;
            end else if (rx_sh == {ALERT_RESP_ADDR, 1'b1} && alert_pend_i) begin
               dec_ack = 1'b1;
               dec_ara = 1'b1;
               dec_nxt = ST_TX;
            end
         end
         ST_CMD: begin
            if (rx_sh <= 8'(MAX_IDX)) begin
               dec_ack = 1'b1;
               dec_nxt = ST_WDAT;
            end
         end
         ST_WDAT: begin
            dec_ack = 1'b1;
            dec_nxt = ST_SKIP;
         end
         default: ;
      endcase
   end

   assign tx_load = ara_mode ? {dev_addr_i, 1'b0} : rd_data_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         nxt_state   <= ST_IDLE;
         ack_ph      <= 1'b0;
         bit_cnt     <= '0;
         rx_sh       <= '0;
         tx_sh       <= '0;
         ara_mode    <= 1'b0;
         sda_oe_o    <= 1'b0;
         alert_clr_o <= 1'b0;
         reg_idx_o   <= '0;
         wr_data_o   <= '0;
         wr_stb_o    <= 1'b0;
         rd_stb_o    <= 1'b0;
      end else begin
         wr_stb_o    <= 1'b0;
         rd_stb_o    <= 1'b0;
         alert_clr_o <= 1'b0;
         if (timeout_i || idle_hit_i || stop_i) begin
            state    <= ST_IDLE;
            ack_ph   <= 1'b0;
            sda_oe_o <= 1'b0;
         end else if (start_i) begin
            state    <= ST_ADDR;
            ack_ph   <= 1'b0;
            bit_cnt  <= '0;
            sda_oe_o <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WDAT: begin
                  if (scl_rise_i && !ack_ph) begin
                     rx_sh   <= {rx_sh[6:0], sda_s_i};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall_i && !ack_ph && bit_cnt == 4'd8) begin
                     ack_ph    <= 1'b1;
                     sda_oe_o  <= dec_ack;
                     nxt_state <= dec_nxt;
                     if (state == ST_ADDR) begin
                        ara_mode <= dec_ara;
                     end
                     if (state == ST_CMD && dec_ack) begin
                        reg_idx_o <= rx_sh[IDX_W-1:0];
                     end
                     if (state == ST_WDAT) begin
                        wr_stb_o  <= 1'b1;
                        wr_data_o <= rx_sh;
                     end
                  end else if (scl_fall_i && ack_ph) begin
                     ack_ph  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= nxt_state;
                     if (nxt_state == ST_TX) begin
                        tx_sh    <= tx_load;
                        sda_oe_o <= ~tx_load[7];
                        rd_stb_o <= ~ara_mode;
                     end else begin
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise_i && !ack_ph) begin
                     if (tx_sh[7] && !sda_s_i) begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_SKIP;
                     end
                  end else if (scl_fall_i && !ack_ph) begin
                     bit_cnt <= bit_cnt + 1'b1;
                     if (bit_cnt == 4'd7) begin
                        sda_oe_o <= 1'b0;
                        ack_ph   <= 1'b1;
                     end else begin
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                        sda_oe_o <= ~tx_sh[6];
                     end
                  end else if (scl_rise_i && ack_ph) begin
                     alert_clr_o <= ara_mode;
                  end else if (scl_fall_i && ack_ph) begin
                     ack_ph <= 1'b0;
                     state  <= ST_SKIP;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_strobe_excl_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb_o && rd_stb_o));

   assert_wr_idx_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> (32'(reg_idx_o) <= MAX_IDX));

   assert_clr_pulse_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      alert_clr_o |=> !alert_clr_o);

   assert_timeout_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      timeout_i |=> !sda_oe_o);

endmodule

// File: rtl/smb_byte_slave.sv
module smb_byte_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter int         TIMEOUT_CYC = 2_500_000,
   parameter int         IDLE_CYC    = 5000,
   parameter int         IDX_W       = 3,
   parameter int         MAX_IDX     = 6,
   parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       strap_i,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic             alert_pend_i,
   output logic             alert_clr_o,
   output logic [IDX_W-1:0] reg_idx_o,
   output logic [7:0]       wr_data_o,
   output logic             wr_stb_o,
   output logic             rd_stb_o,
   input  logic [7:0]       rd_data_i,
   output logic             bus_idle_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (IDLE_CYC < 4 || TIMEOUT_CYC < 4) begin : g_bad_cnt
         $error("IDLE_CYC and TIMEOUT_CYC must be at least 4");
      end
      if (MAX_IDX >= (1 << IDX_W) || MAX_IDX > 255) begin : g_bad_idx
         $error("MAX_IDX must fit in IDX_W bits");
      end
   endgenerate

   logic [6:0] dev_addr;
   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_ev;
   logic       stop_ev;
   logic       timeout_ev;
   logic       idle_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_addr <= {ADDR_PREFIX[3:0], strap_i};
      end
   end

   smb_line_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_ev),
      .stop_o     (stop_ev)
   );

   smb_bus_watch #(
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .IDLE_CYC    (IDLE_CYC)
   ) watch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s_i    (scl_s),
      .sda_s_i    (sda_s),
      .start_i    (start_ev),
      .stop_i     (stop_ev),
      .timeout_o  (timeout_ev),
      .idle_hit_o (idle_hit),
      .bus_idle_o (bus_idle_o)
   );

   smb_byte_fsm #(
      .IDX_W   (IDX_W),
      .MAX_IDX (MAX_IDX)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .dev_addr_i   (dev_addr),
      .sda_s_i      (sda_s),
      .scl_rise_i   (scl_rise),
      .scl_fall_i   (scl_fall),
      .start_i      (start_ev),
      .stop_i       (stop_ev),
      .timeout_i    (timeout_ev),
      .idle_hit_i   (idle_hit),
      .alert_pend_i (alert_pend_i),
      .rd_data_i    (rd_data_i),
      .sda_oe_o     (sda_oe_o),
      .alert_clr_o  (alert_clr_o),
      .reg_idx_o    (reg_idx_o),
      .wr_data_o    (wr_data_o),
      .wr_stb_o     (wr_stb_o),
      .rd_stb_o     (rd_stb_o)
   );

endmodule

// File: tb/smb_byte_slave_tb.sv
module smb_byte_slave_tb_top;

   localparam int         Q     = 6;
   localparam int         TO    = 300;
   localparam int         IDL   = 150;
   localparam logic [6:0] OWN   = 7'h25;
   localparam logic [7:0] ARA_R = 8'h19;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'b101;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       cont_low = 1'b0;
   logic       alert_pend = 1'b0;
   logic       sda_oe;
   logic       alert_clr;
   logic [2:0] reg_idx;
   logic [7:0] wr_data;
   logic       wr_stb;
   logic       rd_stb;
   logic [7:0] rd_data;
   logic       bus_idle;
   logic       sda_line;
   logic [7:0] model [8] = '{default: 8'h00};
   logic [7:0] expv  [8];

   int tests = 0;
   int fails = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int clr_cnt = 0;
   int last_wr_idx = 0;
   int last_wr_dat = 0;
   int last_rd_idx = 0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe & ~cont_low;
   assign rd_data  = model[reg_idx];

   smb_byte_slave #(
      .TIMEOUT_CYC (TO),
      .IDLE_CYC    (IDL)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_i      (strap),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe_o     (sda_oe),
      .alert_pend_i (alert_pend),
      .alert_clr_o  (alert_clr),
      .reg_idx_o    (reg_idx),
      .wr_data_o    (wr_data),
      .wr_stb_o     (wr_stb),
      .rd_stb_o     (rd_stb),
      .rd_data_i    (rd_data),
      .bus_idle_o   (bus_idle)
   );

   always @(posedge clk) begin
      if (wr_stb) begin
         wr_cnt++;
         last_wr_idx = int'(reg_idx);
         last_wr_dat = int'(wr_data);
         model[reg_idx] <= wr_data;
      end
      if (rd_stb) begin
         rd_cnt++;
         last_rd_idx = int'(reg_idx);
      end
      if (alert_clr) clr_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input logic b, output logic r);
      sda_m = b;
      wait_q(Q);
      scl_m = 1'b1;
      wait_q(Q);
      r = sda_line;
      wait_q(Q);
      scl_m = 1'b0;
      wait_q(Q);
   endtask

   task automatic bus_start();
      sda_m = 1'b1;
      wait_q(Q);
      scl_m = 1'b1;
      wait_q(Q);
      sda_m = 1'b0;
      wait_q(Q);
      scl_m = 1'b0;
      wait_q(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      wait_q(Q);
      scl_m = 1'b1;
      wait_q(Q);
      sda_m = 1'b1;
      wait_q(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) put_bit(b[i], r);
      put_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(input logic cont_en, input logic [7:0] cont_b, output logic [7:0] v);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         cont_low = cont_en & ~cont_b[i];
         put_bit(1'b1, r);
         v[i] = r;
      end
      cont_low = 1'b0;
      put_bit(1'b1, r);
   endtask

   task automatic write_txn(input logic [7:0] idx, input logic [7:0] dat,
                            output logic a1, output logic a2, output logic a3);
      bus_start();
      send_byte({OWN, 1'b0}, a1);
      send_byte(idx, a2);
      send_byte(dat, a3);
      bus_stop();
   endtask

   task automatic read_txn(input logic [7:0] idx, output logic [7:0] v, output logic ok);
      logic a1, a2, a3;
      bus_start();
      send_byte({OWN, 1'b0}, a1);
      send_byte(idx, a2);
      bus_start();
      send_byte({OWN, 1'b1}, a3);
      recv_byte(1'b0, 8'h00, v);
      bus_stop();
      ok = a1 & a2 & a3;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic a1, a2, a3, a4, ok;
      logic [7:0] v;
      int w0, r0, c0;
      wait_q(5);
      rst_n = 1'b1;
      wait_q(5);
      // R9 reset state
      chk(sda_oe == 1'b0, "R9 sda_oe after reset", int'(sda_oe), 0);
      chk(bus_idle == 1'b1, "R9 bus_idle after reset", int'(bus_idle), 1);
      chk(wr_cnt == 0 && rd_cnt == 0 && clr_cnt == 0, "R9 no strobes", wr_cnt + rd_cnt + clr_cnt, 0);

      // R2: straps move after reset; R1 sweep of every write address
      strap = 3'b010;
      for (int a = 0; a < 128; a++) begin
         bus_start();
         if (a == 0) chk(bus_idle == 1'b0, "R8 busy after start", int'(bus_idle), 0);
         send_byte({7'(a), 1'b0}, a1);
         bus_stop();
         chk(a1 == (7'(a) == OWN), (7'(a) == OWN) ? "R1 own address ack" : "R1 R2 foreign address nack",
             int'(a1), int'(7'(a) == OWN));
         if (a == 0) chk(bus_idle == 1'b1, "R8 idle after stop", int'(bus_idle), 1);
      end

      // R3 index sweep with writes
      for (int i = 0; i < 8; i++) begin
         w0 = wr_cnt;
         v = 8'(i * 37 + 5);
         write_txn(8'(i), v, a1, a2, a3);
         if (i <= 6) begin
            expv[i] = v;
            chk(a1 && a2 && a3, "R3 write acks", int'({a1, a2, a3}), 7);
            chk(wr_cnt == w0 + 1 && last_wr_idx == i && last_wr_dat == int'(v),
                "R3 write strobe", last_wr_dat, int'(v));
         end else begin
            chk(a1 && !a2, "R3 index above max nacked", int'({a1, a2}), 2);
            chk(wr_cnt == w0, "R3 no strobe for bad index", wr_cnt - w0, 0);
         end
      end
      w0 = wr_cnt;
      write_txn(8'd200, 8'h11, a1, a2, a3);
      chk(!a2 && wr_cnt == w0, "R3 large index rejected", int'(a2), 0);

      // R10 extra data byte
      w0 = wr_cnt;
      bus_start();
      send_byte({OWN, 1'b0}, a1);
      send_byte(8'd2, a2);
      send_byte(8'hC3, a3);
      send_byte(8'h3C, a4);
      bus_stop();
      expv[2] = 8'hC3;
      chk(a3 && !a4, "R10 second data byte nacked", int'({a3, a4}), 2);
      chk(wr_cnt == w0 + 1 && last_wr_dat == 'hC3, "R10 single write strobe", wr_cnt - w0, 1);

      // R4 read sweep
      for (int i = 0; i < 7; i++) begin
         r0 = rd_cnt;
         read_txn(8'(i), v, ok);
         chk(ok, "R4 read acks", int'(ok), 1);
         chk(v == expv[i], "R4 read data", int'(v), int'(expv[i]));
         chk(rd_cnt == r0 + 1 && last_rd_idx == i, "R4 read strobe", last_rd_idx, i);
      end

      // R5 alert response without pending alert
      c0 = clr_cnt;
      bus_start();
      send_byte(ARA_R, a1);
      bus_stop();
      chk(!a1 && clr_cnt == c0, "R5 alert address nacked when idle", int'(a1), 0);

      // R5 alert response with pending alert
      alert_pend = 1'b1;
      bus_start();
      send_byte(ARA_R, a1);
      recv_byte(1'b0, 8'h00, v);
      bus_stop();
      chk(a1, "R5 alert address acked", int'(a1), 1);
      chk(v == {OWN, 1'b0}, "R5 returned address byte", int'(v), int'({OWN, 1'b0}));
      chk(clr_cnt == c0 + 1, "R5 alert clear pulse", clr_cnt - c0, 1);

      // R6 arbitration loss against a contender sending 0x44
      c0 = clr_cnt;
      bus_start();
      send_byte(ARA_R, a1);
      recv_byte(1'b1, 8'h44, v);
      bus_stop();
      chk(v == 8'h44, "R6 slave left bus after loss", int'(v), 'h44);
      chk(clr_cnt == c0, "R6 no alert clear after loss", clr_cnt - c0, 0);
      alert_pend = 1'b0;

      // R7 timeout while slave drives acknowledge
      bus_start();
      for (int i = 7; i >= 0; i--) put_bit(OWN_W(i), a1);
      wait_q(Q);
      chk(sda_oe == 1'b1, "R1 ack driven in ninth clock", int'(sda_oe), 1);
      wait_q(TO + 20);
      chk(sda_oe == 1'b0, "R7 released after timeout", int'(sda_oe), 0);
      sda_m = 1'b1;
      scl_m = 1'b1;
      wait_q(IDL - 20);
      chk(bus_idle == 1'b0, "R8 not idle before threshold", int'(bus_idle), 0);
      wait_q(40);
      chk(bus_idle == 1'b1, "R8 idle after high window", int'(bus_idle), 1);
      read_txn(8'd5, v, ok);
      chk(ok && v == expv[5], "R7 recovery read", int'(v), int'(expv[5]));

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   function automatic logic OWN_W(input int i);
      logic [7:0] b;
      b = {OWN, 1'b0};
      return b[i];
   endfunction

endmodule